// File: doc/BRIEF.md
# Disc Word Buffer with Overrun Detection and Retry Count

This block holds one 16-bit data word between a DMA channel and a disc controller that moves words at a fixed rate. One data-ready flip-flop tells both sides whether the word register is full. Every strobe, from either side, inverts that flip-flop instead of setting or clearing it. When the controller's fixed-rate demand finds the buffer in the wrong state, an overrun flip-flop latches. This covers a word arriving into a full buffer and a word requested from an empty one.

The block also tracks the channel program. It holds a busy flag, an input-direction flip-flop and an output-direction flip-flop, each inverted by a channel toggle strobe. It flags a controller transfer whose direction does not match the active one. It passes end-of-data to the controller. A power-fail warning or channel transfer error aborts the transfer.

A small retry counter is loaded by the controller. It lets the channel repeat a failed transfer a fixed number of times before an interrupt is raised and the channel program is stopped. Disc mechanics and the execution of channel orders lie outside the block; both sides' strobes arrive as single-cycle inputs on one clock.

Top module: `disc_word_buffer`

## Requirements
- R1: After reset, every output is 0: data ready, overrun, transfer error, end-of-data, both direction flags, busy, service request, retry count, device end, jump met, interrupt and abort.
- R2: Each of the four strobes inverts data ready one cycle later: channel read, channel write, controller input word and controller output word. Two strobes in the same cycle cancel. A channel write loads `cpu_wdata` into `buf_word`. A controller input word loads `ctl_din` into `buf_word`.
- R3: A controller input word while data ready is 1 sets the overrun flag. A controller output request while data ready is 0 also sets it.
- R4: `ovr_to_ctl` shows the overrun flag only while `xfer_err` is 0. The overrun flag itself is kept, and it appears once the error clears.
- R5: A wait load with `wait_bit`=1 forces data ready to 1 on the next cycle. A wait load with `wait_bit`=0 leaves data ready unchanged.
- R6: A get-command pulse clears data ready, overrun and end-of-data. It raises `chan_sr` for exactly the following cycle.
- R7: A controller word during an active transfer sets `xfer_err` when the word does not match the active direction. An input word needs `in_xfer`=1 and an output word needs `out_xfer`=1. A matching word leaves `xfer_err` at 0. A channel-program start clears `xfer_err`.
- R8: On a read, `eot` with the toggle that ends input marks end-of-data, and `eod_to_ctl` rises on the next cycle. On a write, `eot` with the channel write and the output toggle marks the last word. `eod_to_ctl` then rises one cycle after the controller takes that word.
- R9: An abort request sets `xfer_err`. While busy, the same abort also clears `in_xfer` and `out_xfer` and sets `eod_to_ctl`, all in one cycle. While not busy, the direction flags are kept.
- R10: A set-retry pulse loads `retry_cnt` from `ctl_din[3:0]`. A device-end event with a nonzero count decrements the count and sets `dev_end` and `jump_met`, without an interrupt.
- R11: A device-end event with a count of 0 sets `irq` and pulses `abort_chan` for one cycle.
- R12: Ending the channel program (`sio_end`) clears `sio_busy` and the retry count. Starting it (`sio_start`) sets busy and clears `irq`, `dev_end` and `jump_met`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_stb | input | 1 | Channel takes the buffered word |
| cpu_wr_stb | input | 1 | Channel writes a word into the buffer |
| cpu_wdata | input | 16 | Word from the channel |
| ctl_in_stb | input | 1 | Controller delivers an input word |
| ctl_out_stb | input | 1 | Controller takes an output word |
| ctl_din | input | 16 | Word or retry count from the controller |
| ctl_get_cmd | input | 1 | Controller accepts the pending command |
| ctl_set_retry | input | 1 | Load the retry counter |
| ctl_dev_end | input | 1 | Controller reports a retryable device end |
| wait_ld | input | 1 | First control word is being stored |
| wait_bit | input | 1 | Wait bit of that control word |
| tgl_in_xfer | input | 1 | Invert the input-direction flag |
| tgl_out_xfer | input | 1 | Invert the output-direction flag |
| eot | input | 1 | Channel marks the last word |
| sio_start | input | 1 | Channel program begins |
| sio_end | input | 1 | Channel program ends |
| abort_req | input | 1 | Power-fail warning or channel transfer error |
| buf_word | output | 16 | Buffered word, seen by both sides |
| data_ready | output | 1 | Buffer full flag |
| ovr_to_ctl | output | 1 | Overrun reported to the controller |
| xfer_err | output | 1 | Transfer error flag |
| eod_to_ctl | output | 1 | End-of-data reported to the controller |
| in_xfer | output | 1 | Input transfer active |
| out_xfer | output | 1 | Output transfer active |
| sio_busy | output | 1 | Channel program running |
| chan_sr | output | 1 | Service request to the channel |
| retry_cnt | output | 4 | Retries left |
| dev_end | output | 1 | Device end flag |
| jump_met | output | 1 | Conditional-jump condition for the channel |
| irq | output | 1 | Interrupt request |
| abort_chan | output | 1 | One-cycle abort of the channel program |

## Verification
Because data ready is inverted rather than set, one wrong value of it persists. It flips the meaning of every later strobe, and it shows as a spurious or missing overrun on the very next controller word. The bench therefore checks data ready after every strobe and pairs strobes with each other in the same cycle. A counter that loses a step shows one device-end event early or late, as a premature or missing interrupt and abort pulse. Direction or end-of-data state left behind after an abort shows as a false transfer error on the following controller word. All of these appear one clock after the stimulus that exposes them.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

   typedef struct packed {
      logic in_x;
      logic out_x;
   } dwb_dir_t;

   // odd number of simultaneous strobes inverts the ready flag
   function automatic logic dwb_odd(input logic [3:0] v);
      return ^v;
   endfunction

endpackage

// File: rtl/dwb_ready_ovr.sv
module dwb_ready_ovr
   import dwb_pkg::*;
#(
   parameter int N_STB = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_STB-1:0] stb,      // {ctl_out, ctl_in, cpu_wr, cpu_rd}
   input  logic             get_cmd,
   input  logic             wait_force,
   output logic             ready_q,
   output logic             ovr_q
);
   localparam int IDX_CIN  = 2;
   localparam int IDX_COUT = 3;

   if (N_STB != 4) begin : g_bad_stb
      $error("dwb_ready_ovr: strobe vector must be 4 wide");
   end

   logic ovr_hit;
   assign ovr_hit = (stb[IDX_CIN] & ready_q) | (stb[IDX_COUT] & ~ready_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (get_cmd)         ready_q <= 1'b0;
         else if (wait_force) ready_q <= 1'b1;
         else if (dwb_odd(stb)) ready_q <= ~ready_q;

         if (get_cmd)      ovr_q <= 1'b0;
         else if (ovr_hit) ovr_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dwb_xfer_ctl.sv
module dwb_xfer_ctl
   import dwb_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sio_start,
   input  logic     sio_end,
   input  logic     tgl_in,
   input  logic     tgl_out,
   input  logic     eot,
   input  logic     cpu_wr,
   input  logic     ctl_in,
   input  logic     ctl_out,
   input  logic     get_cmd,
   input  logic     abort,
   output logic     busy_q,
   output dwb_dir_t dir_q,
   output logic     err_q,
   output logic     eod_flag_q
);
   logic active, mismatch, kill, eod_mark, eod_raise;

   assign active    = dir_q.in_x | dir_q.out_x;
   assign mismatch  = active & ((ctl_in & ~dir_q.in_x) | (ctl_out & ~dir_q.out_x));
   assign kill      = abort & busy_q;
   assign eod_mark  = (eot & tgl_in & dir_q.in_x) | (eot & tgl_out & cpu_wr) | kill;

   logic eod_q;
   assign eod_raise = (eot & tgl_in & dir_q.in_x) | (eod_q & ctl_out) | kill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         dir_q      <= '0;
         err_q      <= 1'b0;
         eod_q      <= 1'b0;
         eod_flag_q <= 1'b0;
      end else begin
         if (sio_end)        busy_q <= 1'b0;
         else if (sio_start) busy_q <= 1'b1;

         if (kill) begin
            dir_q <= '0;
         end else begin
            if (tgl_in)  dir_q.in_x  <= ~dir_q.in_x;
            if (tgl_out) dir_q.out_x <= ~dir_q.out_x;
         end

         if (abort | mismatch) err_q <= 1'b1;
         else if (sio_start)   err_q <= 1'b0;

         if (eod_mark)     eod_q <= 1'b1;
         else if (get_cmd) eod_q <= 1'b0;

         if (eod_raise)    eod_flag_q <= 1'b1;
         else if (get_cmd) eod_flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dwb_retry.sv
module dwb_retry #(
   parameter int RETRY_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [RETRY_W-1:0] load_val,
   input  logic               dev_end_ev,
   input  logic               sio_start,
   input  logic               sio_end,
   input  logic               get_cmd,
   output logic [RETRY_W-1:0] cnt_q,
   output logic               dev_end_q,
   output logic               jump_q,
   output logic               irq_q,
   output logic               abort_q
);
   localparam logic [RETRY_W-1:0] CNT_ONE = RETRY_W'(1);

   logic exhausted;
   assign exhausted = dev_end_ev & (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         dev_end_q <= 1'b0;
         jump_q    <= 1'b0;
         irq_q     <= 1'b0;
         abort_q   <= 1'b0;
      end else begin
         if (sio_end)                          cnt_q <= '0;
         else if (load)                        cnt_q <= load_val;
         else if (dev_end_ev && cnt_q != '0)   cnt_q <= cnt_q - CNT_ONE;

         if (dev_end_ev)                  dev_end_q <= 1'b1;
         else if (sio_start || get_cmd)   dev_end_q <= 1'b0;

         if (dev_end_ev)                  jump_q <= 1'b1;
         else if (sio_start || get_cmd)   jump_q <= 1'b0;

         if (exhausted)      irq_q <= 1'b1;
         else if (sio_start) irq_q <= 1'b0;

         abort_q <= exhausted;
      end
   end
endmodule

// File: rtl/disc_word_buffer.sv
module disc_word_buffer
   import dwb_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int RETRY_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_rd_stb,
   input  logic               cpu_wr_stb,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic               ctl_in_stb,
   input  logic               ctl_out_stb,
   input  logic [DATA_W-1:0]  ctl_din,
   input  logic               ctl_get_cmd,
   input  logic               ctl_set_retry,
   input  logic               ctl_dev_end,
   input  logic               wait_ld,
   input  logic               wait_bit,
   input  logic               tgl_in_xfer,
   input  logic               tgl_out_xfer,
   input  logic               eot,
   input  logic               sio_start,
   input  logic               sio_end,
   input  logic               abort_req,
   output logic [DATA_W-1:0]  buf_word,
   output logic               data_ready,
   output logic               ovr_to_ctl,
   output logic               xfer_err,
   output logic               eod_to_ctl,
   output logic               in_xfer,
   output logic               out_xfer,
   output logic               sio_busy,
   output logic               chan_sr,
   output logic [RETRY_W-1:0] retry_cnt,
   output logic               dev_end,
   output logic               jump_met,
   output logic               irq,
   output logic               abort_chan
);
   localparam int N_STB = 4;

   if (RETRY_W < 1 || RETRY_W > DATA_W) begin : g_bad_retry
      $error("disc_word_buffer: RETRY_W must lie in 1..DATA_W");
   end

   logic [DATA_W-1:0] buf_q;
   logic              sr_q;
   logic              ovr_raw;
   dwb_dir_t          dir;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         sr_q  <= 1'b0;
      end else begin
         if (ctl_in_stb)      buf_q <= ctl_din;
         else if (cpu_wr_stb) buf_q <= cpu_wdata;
         sr_q <= ctl_get_cmd;
      end
   end

   dwb_ready_ovr #(.N_STB(N_STB)) u_ready (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        ({ctl_out_stb, ctl_in_stb, cpu_wr_stb, cpu_rd_stb}),
      .get_cmd    (ctl_get_cmd),
      .wait_force (wait_ld & wait_bit),
      .ready_q    (data_ready),
      .ovr_q      (ovr_raw)
   );

   dwb_xfer_ctl u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sio_start  (sio_start),
      .sio_end    (sio_end),
      .tgl_in     (tgl_in_xfer),
      .tgl_out    (tgl_out_xfer),
      .eot        (eot),
      .cpu_wr     (cpu_wr_stb),
      .ctl_in     (ctl_in_stb),
      .ctl_out    (ctl_out_stb),
      .get_cmd    (ctl_get_cmd),
      .abort      (abort_req),
      .busy_q     (sio_busy),
      .dir_q      (dir),
      .err_q      (xfer_err),
      .eod_flag_q (eod_to_ctl)
   );

   dwb_retry #(.RETRY_W(RETRY_W)) u_retry (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ctl_set_retry),
      .load_val   (ctl_din[RETRY_W-1:0]),
      .dev_end_ev (ctl_dev_end),
      .sio_start  (sio_start),
      .sio_end    (sio_end),
      .get_cmd    (ctl_get_cmd),
      .cnt_q      (retry_cnt),
      .dev_end_q  (dev_end),
      .jump_q     (jump_met),
      .irq_q      (irq),
      .abort_q    (abort_chan)
   );

   assign buf_word   = buf_q;
   assign chan_sr    = sr_q;
   assign in_xfer    = dir.in_x;
   assign out_xfer   = dir.out_x;
   assign ovr_to_ctl = ovr_raw & ~xfer_err;
endmodule

// File: rtl/disc_word_buffer_chk.sv
module disc_word_buffer_chk #(
   parameter int RETRY_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_rd_stb,
   input logic               cpu_wr_stb,
   input logic               ctl_in_stb,
   input logic               ctl_out_stb,
   input logic               ctl_get_cmd,
   input logic               ctl_set_retry,
   input logic               ctl_dev_end,
   input logic               wait_ld,
   input logic               wait_bit,
   input logic               sio_end,
   input logic               abort_req,
   input logic               data_ready,
   input logic               ovr_to_ctl,
   input logic               xfer_err,
   input logic               eod_to_ctl,
   input logic               in_xfer,
   input logic               out_xfer,
   input logic               sio_busy,
   input logic               chan_sr,
   input logic [RETRY_W-1:0] retry_cnt,
   input logic               irq,
   input logic               abort_chan
);
   // R2
   p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({cpu_rd_stb, cpu_wr_stb, ctl_in_stb, ctl_out_stb}) == 1
       && !ctl_get_cmd && !(wait_ld && wait_bit))
      |=> data_ready != $past(data_ready));

   // R3
   p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_in_stb && data_ready && !ctl_get_cmd) |=> (ovr_to_ctl || xfer_err));

   // R5
   p_wait_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_ld && wait_bit && !ctl_get_cmd) |=> data_ready);

   // R6
   p_get_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_get_cmd |=> (!data_ready && !ovr_to_ctl && chan_sr));

   // R9
   p_abort_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && sio_busy) |=> (!in_xfer && !out_xfer && xfer_err && eod_to_ctl));

   // R10
   p_retry_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_dev_end && retry_cnt != '0 && !sio_end && !ctl_set_retry)
      |=> retry_cnt == $past(retry_cnt) - RETRY_W'(1));

   // R11
   p_exhaust_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_dev_end && retry_cnt == '0) |=> (irq && abort_chan));

   // R12
   p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sio_end |=> (retry_cnt == '0 && !sio_busy));
endmodule

bind disc_word_buffer disc_word_buffer_chk #(.RETRY_W(RETRY_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_rd_stb    (cpu_rd_stb),
   .cpu_wr_stb    (cpu_wr_stb),
   .ctl_in_stb    (ctl_in_stb),
   .ctl_out_stb   (ctl_out_stb),
   .ctl_get_cmd   (ctl_get_cmd),
   .ctl_set_retry (ctl_set_retry),
   .ctl_dev_end   (ctl_dev_end),
   .wait_ld       (wait_ld),
   .wait_bit      (wait_bit),
   .sio_end       (sio_end),
   .abort_req     (abort_req),
   .data_ready    (data_ready),
   .ovr_to_ctl    (ovr_to_ctl),
   .xfer_err      (xfer_err),
   .eod_to_ctl    (eod_to_ctl),
   .in_xfer       (in_xfer),
   .out_xfer      (out_xfer),
   .sio_busy      (sio_busy),
   .chan_sr       (chan_sr),
   .retry_cnt     (retry_cnt),
   .irq           (irq),
   .abort_chan    (abort_chan)
);

// File: tb/disc_word_buffer_tb.sv
module disc_word_buffer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_rd_stb = 0, cpu_wr_stb = 0, ctl_in_stb = 0, ctl_out_stb = 0;
   logic [15:0] cpu_wdata = '0, ctl_din = '0;
   logic        ctl_get_cmd = 0, ctl_set_retry = 0, ctl_dev_end = 0;
   logic        wait_ld = 0, wait_bit = 0, tgl_in_xfer = 0, tgl_out_xfer = 0, eot = 0;
   logic        sio_start = 0, sio_end = 0, abort_req = 0;
   logic [15:0] buf_word;
   logic        data_ready, ovr_to_ctl, xfer_err, eod_to_ctl, in_xfer, out_xfer;
   logic        sio_busy, chan_sr, dev_end, jump_met, irq, abort_chan;
   logic [3:0]  retry_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #10 clk = ~clk;

   disc_word_buffer dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_rd_stb(cpu_rd_stb), .cpu_wr_stb(cpu_wr_stb), .cpu_wdata(cpu_wdata),
      .ctl_in_stb(ctl_in_stb), .ctl_out_stb(ctl_out_stb), .ctl_din(ctl_din),
      .ctl_get_cmd(ctl_get_cmd), .ctl_set_retry(ctl_set_retry), .ctl_dev_end(ctl_dev_end),
      .wait_ld(wait_ld), .wait_bit(wait_bit), .tgl_in_xfer(tgl_in_xfer),
      .tgl_out_xfer(tgl_out_xfer), .eot(eot), .sio_start(sio_start), .sio_end(sio_end),
      .abort_req(abort_req), .buf_word(buf_word), .data_ready(data_ready),
      .ovr_to_ctl(ovr_to_ctl), .xfer_err(xfer_err), .eod_to_ctl(eod_to_ctl),
      .in_xfer(in_xfer), .out_xfer(out_xfer), .sio_busy(sio_busy), .chan_sr(chan_sr),
      .retry_cnt(retry_cnt), .dev_end(dev_end), .jump_met(jump_met), .irq(irq),
      .abort_chan(abort_chan)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // strobes set before the call act on the next rising edge; outputs are sampled after it
   task automatic tick();
      @(negedge clk);
      {cpu_rd_stb, cpu_wr_stb, ctl_in_stb, ctl_out_stb} = '0;
      {ctl_get_cmd, ctl_set_retry, ctl_dev_end, wait_ld, wait_bit} = '0;
      {tgl_in_xfer, tgl_out_xfer, eot, sio_start, sio_end, abort_req} = '0;
   endtask

   task automatic t_reset();
      chk("R1 ready", data_ready, 0);   chk("R1 ovr", ovr_to_ctl, 0);
      chk("R1 err", xfer_err, 0);       chk("R1 eod", eod_to_ctl, 0);
      chk("R1 dir", {in_xfer, out_xfer}, 0); chk("R1 busy", sio_busy, 0);
      chk("R1 sr", chan_sr, 0);         chk("R1 cnt", retry_cnt, 0);
      chk("R1 flags", {dev_end, jump_met, irq, abort_chan}, 0);
   endtask

   task automatic t_toggle();
      cpu_wr_stb = 1; cpu_wdata = 16'hA5A5; tick();
      chk("R2 wr ready", data_ready, 1); chk("R2 wr data", buf_word, 16'hA5A5);
      ctl_out_stb = 1; tick();
      chk("R2 out ready", data_ready, 0); chk("R3 no underrun", ovr_to_ctl, 0);
      cpu_rd_stb = 1; cpu_wr_stb = 1; cpu_wdata = 16'h0F0F; tick();
      chk("R2 pair cancels", data_ready, 0);
      ctl_in_stb = 1; ctl_din = 16'h1234; tick();
      chk("R2 in ready", data_ready, 1); chk("R2 in data", buf_word, 16'h1234);
      chk("R3 no overrun", ovr_to_ctl, 0);
      cpu_rd_stb = 1; tick();
      chk("R2 rd ready", data_ready, 0);
   endtask

   task automatic t_overrun();
      ctl_out_stb = 1; tick();
      chk("R3 underrun", ovr_to_ctl, 1); chk("R2 toggled", data_ready, 1);
      ctl_get_cmd = 1; tick();
      chk("R6 ready clr", data_ready, 0); chk("R6 ovr clr", ovr_to_ctl, 0);
      chk("R6 sr", chan_sr, 1);
      tick();
      chk("R6 sr one cycle", chan_sr, 0);
      cpu_wr_stb = 1; tick();
      ctl_in_stb = 1; tick();
      chk("R3 overrun", ovr_to_ctl, 1);
      ctl_get_cmd = 1; tick();
   endtask

   task automatic t_wait();
      wait_ld = 1; wait_bit = 0; tick();
      chk("R5 bit0 no effect", data_ready, 0);
      wait_ld = 1; wait_bit = 1; tick();
      chk("R5 forced", data_ready, 1);
      wait_ld = 1; wait_bit = 1; tick();
      chk("R5 stays set", data_ready, 1);
      ctl_get_cmd = 1; tick();
   endtask

   task automatic t_direction();
      sio_start = 1; tick();
      tgl_in_xfer = 1; tick();
      chk("R7 in active", in_xfer, 1);
      ctl_in_stb = 1; tick();
      chk("R7 match no err", xfer_err, 0);
      cpu_rd_stb = 1; tick();
      eot = 1; tgl_in_xfer = 1; tick();
      chk("R8 read eod", eod_to_ctl, 1); chk("R8 in ended", in_xfer, 0);
      ctl_get_cmd = 1; tick();
      chk("R6 eod clr", eod_to_ctl, 0);
      tgl_out_xfer = 1; tick();
      ctl_in_stb = 1; tick();
      chk("R7 mismatch", xfer_err, 1);
      ctl_in_stb = 1; tick();
      chk("R4 gated", ovr_to_ctl, 0);
      sio_end = 1; tick();
      sio_start = 1; tick();
      chk("R7 err cleared", xfer_err, 0);
      chk("R4 kept flag shows", ovr_to_ctl, 1);
      ctl_get_cmd = 1; tgl_out_xfer = 1; tick();
   endtask

   task automatic t_write_eod();
      tgl_out_xfer = 1; tick();
      cpu_wr_stb = 1; eot = 1; tgl_out_xfer = 1; tick();
      chk("R8 wr not yet", eod_to_ctl, 0); chk("R8 out ended", out_xfer, 0);
      ctl_out_stb = 1; tick();
      chk("R8 write eod", eod_to_ctl, 1); chk("R2 drained", data_ready, 0);
      ctl_get_cmd = 1; tick();
   endtask

   task automatic t_abort();
      tgl_in_xfer = 1; tgl_out_xfer = 1; tick();
      abort_req = 1; tick();
      chk("R9 dirs clr", {in_xfer, out_xfer}, 0); chk("R9 err", xfer_err, 1);
      chk("R9 eod", eod_to_ctl, 1);
      sio_end = 1; ctl_get_cmd = 1; tick();
      tgl_in_xfer = 1; tick();
      abort_req = 1; tick();
      chk("R9 idle keeps dir", in_xfer, 1); chk("R9 idle err", xfer_err, 1);
      tgl_in_xfer = 1; tick();
   endtask

   task automatic t_retry();
      sio_start = 1; tick();
      chk("R12 busy", sio_busy, 1);
      ctl_set_retry = 1; ctl_din = 16'hFFF2; tick();
      chk("R10 load", retry_cnt, 2);
      ctl_dev_end = 1; tick();
      chk("R10 dec", retry_cnt, 1); chk("R10 flags", {dev_end, jump_met}, 3);
      chk("R10 no irq", irq, 0);
      ctl_dev_end = 1; tick();
      chk("R10 dec2", retry_cnt, 0); chk("R11 no irq yet", irq, 0);
      ctl_dev_end = 1; tick();
      chk("R11 irq", irq, 1); chk("R11 abort", abort_chan, 1);
      chk("R11 cnt holds", retry_cnt, 0);
      tick();
      chk("R11 abort pulse", abort_chan, 0); chk("R11 irq stays", irq, 1);
      ctl_set_retry = 1; ctl_din = 16'h0005; tick();
      sio_end = 1; tick();
      chk("R12 cnt clr", retry_cnt, 0); chk("R12 idle", sio_busy, 0);
      sio_start = 1; tick();
      chk("R12 start clears", {irq, dev_end, jump_met}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_toggle();
      t_overrun();
      t_wait();
      t_direction();
      t_write_eod();
      t_abort();
      t_retry();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule